// File: doc/BRIEF.md
# Quadrant-multiplexed almost-full status bus

This block reports the almost-full state of 32 queues over a shared 8-bit status bus, one quadrant of eight queues at a time. The per-queue flags are produced in the read-clock domain. They enter through a synchronizer clocked by the write clock, so a read that frees space is reported a fixed number of write-clock edges after it happens. A selection strobe carries an address that holds a device ID and a queue number. The two low bits of the queue number pick the quadrant, and the device ID decides whether this device drives the bus at all. The new selection appears on the bus one cycle after it is captured.

Several devices can sit on one bus. Each device has its own ID parameter. It raises its output enable only while the latest selection names it, so an output buffer outside the block can release the lines to high impedance when another device is addressed. A separate discrete flag reports the almost-full state of the active write queue, which is chosen with its own strobe and queue number. All flags are active low: a 0 means almost full.

Top module: `afbus_status`

## Requirements
- R1: While reset is asserted and after it is released with no other stimulus, status_oe is 0, status_bus is 8'hFF and wq_af_n is 1.
- R2: When quadrant q (sel_addr[1:0]) is displayed, status_bus bit b carries the flag of queue 4*b+q. For example, queue 31 appears on bit 7 of quadrant 3.
- R3: A selection strobe is sampled on a rising edge and updates the bus on the next rising edge. After the sampling edge the outputs still reflect the old selection.
- R4: status_oe goes to 1 after the edge that follows a sampled selection whose device field sel_addr[7:5] equals DEV_ID. It goes to 0 at the same point when the device field differs.
- R5: A change on af_rd_n that is stable before rising edge k shows on status_bus and wq_af_n after edge k+2, and not earlier. When neither the flags nor the selection change, the bus holds its value.
- R6: A write-queue strobe with wq_addr sampled on an edge makes wq_af_n follow that queue's synchronized flag after the next edge. Without a strobe, the active write queue is kept.
- R7: Without a selection strobe the displayed quadrant and the device match are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Active-low reset, synchronous to wclk |
| af_rd_n | input | 32 | Per-queue almost-full flags from the read domain, active low |
| sel_strobe | input | 1 | Selects a new quadrant and device for the status bus |
| sel_addr | input | 8 | Device ID in bits 7:5, queue number in bits 4:0 (bits 1:0 give the quadrant) |
| wq_strobe | input | 1 | Loads a new active write queue |
| wq_addr | input | 5 | Queue number of the active write queue |
| status_bus | output | 8 | Almost-full flags of the displayed quadrant, active low |
| status_oe | output | 1 | High while this device should drive status_bus |
| wq_af_n | output | 1 | Almost-full flag of the active write queue, active low |

## Verification
A bus selection is due two edges after its strobe is presented. A write-queue change is due one edge after the strobe edge, and a flag change three edges after it is presented. The directed sequence counts edges one at a time and samples on every falling edge. In that way it confirms that the old value persists up to the cycle in which the new value is due, for example bit 7 for queue 31 and the enable for a matching versus a foreign device ID. The random phase drives all inputs on falling edges from a fixed seed. It compares every output on the following falling edge against a bench model that keeps the pipeline latencies stated in the requirements.

// File: rtl/afbus_pkg.sv
package afbus_pkg;
    localparam int AF_NUM_Q   = 32;
    localparam int AF_BUS_W   = 8;
    localparam int AF_ID_W    = 3;
    localparam int AF_STAGES  = 2;
endpackage

// File: rtl/afbus_sync.sv
module afbus_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/afbus_quad_mux.sv
module afbus_quad_mux #(
    parameter int NUM_Q = 32,
    parameter int BUS_W = 8,
    localparam int QUADS  = NUM_Q / BUS_W,
    localparam int QUAD_W = (QUADS > 1) ? $clog2(QUADS) : 1
) (
    input  logic [NUM_Q-1:0]  flags,
    input  logic [QUAD_W-1:0] quad,
    output logic [BUS_W-1:0]  bus
);
    for (genvar b = 0; b < BUS_W; b++) begin : g_bit
        logic [QUADS-1:0] group;
        for (genvar g = 0; g < QUADS; g++) begin : g_grp
            assign group[g] = flags[b*QUADS + g];
        end
        assign bus[b] = group[quad];
    end
endmodule

// File: rtl/afbus_status.sv
module afbus_status
    import afbus_pkg::*;
#(
    parameter int NUM_Q       = AF_NUM_Q,
    parameter int BUS_W       = AF_BUS_W,
    parameter int ID_W        = AF_ID_W,
    parameter int DEV_ID      = 5,
    parameter int SYNC_STAGES = AF_STAGES,
    localparam int QUADS  = NUM_Q / BUS_W,
    localparam int QUAD_W = (QUADS > 1) ? $clog2(QUADS) : 1,
    localparam int QID_W  = $clog2(NUM_Q),
    localparam int ADDR_W = ID_W + QID_W
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic [NUM_Q-1:0]  af_rd_n,
    input  logic              sel_strobe,
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              wq_strobe,
    input  logic [QID_W-1:0]  wq_addr,
    output logic [BUS_W-1:0]  status_bus,
    output logic              status_oe,
    output logic              wq_af_n
);
    typedef struct packed {
        logic [QUAD_W-1:0] quad;
        logic              match;
        logic [QID_W-1:0]  wq;
        logic [BUS_W-1:0]  bus;
        logic              oe;
        logic              paf;
    } state_t;

    state_t d, q;
    logic [NUM_Q-1:0] flags_sync;
    logic [BUS_W-1:0] quad_bits;

    afbus_sync #(.W(NUM_Q), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (wclk),
        .rst_n (wrst_n),
        .din   (af_rd_n),
        .dout  (flags_sync)
    );

    afbus_quad_mux #(.NUM_Q(NUM_Q), .BUS_W(BUS_W)) i_mux (
        .flags (flags_sync),
        .quad  (q.quad),
        .bus   (quad_bits)
    );

    always_comb begin
        d = q;
        if (sel_strobe) begin
            d.quad  = sel_addr[QUAD_W-1:0];
            d.match = (sel_addr[ADDR_W-1 -: ID_W] == ID_W'(DEV_ID));
        end
        if (wq_strobe) begin
            d.wq = wq_addr;
        end
        d.bus = quad_bits;
        d.oe  = q.match;
        d.paf = flags_sync[q.wq];
    end

    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            q.quad  <= '0;
            q.match <= 1'b0;
            q.wq    <= '0;
            q.bus   <= '1;
            q.oe    <= 1'b0;
            q.paf   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign status_bus = q.bus;
    assign status_oe  = q.oe;
    assign wq_af_n    = q.paf;

    // R4
    foreign_release_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        (sel_strobe && (sel_addr[ADDR_W-1 -: ID_W] != ID_W'(DEV_ID))) |=> ##1 !status_oe);

    // R5
    bus_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        ($stable(flags_sync) && $stable(q.quad) && $stable(q.match)) |=> ($stable(status_bus) && $stable(status_oe)));

    // R6
    wq_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        ($stable(flags_sync) && $stable(q.wq)) |=> $stable(wq_af_n));

    // R7
    sel_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        !sel_strobe |=> ($stable(q.quad) && $stable(q.match)));
endmodule

// File: tb/test_afbus_status.sv
module test_afbus_status;
    localparam int MYID = 5;

    logic        wclk = 1'b0;
    logic        wrst_n;
    logic [31:0] af_rd_n;
    logic        sel_strobe;
    logic [7:0]  sel_addr;
    logic        wq_strobe;
    logic [4:0]  wq_addr;
    logic [7:0]  status_bus;
    logic        status_oe;
    logic        wq_af_n;

    int checks = 0;
    int failures = 0;
    bit model_on = 0;

    always #2 wclk = ~wclk;

    afbus_status i_afbus_status (
        .wclk(wclk), .wrst_n(wrst_n), .af_rd_n(af_rd_n),
        .sel_strobe(sel_strobe), .sel_addr(sel_addr),
        .wq_strobe(wq_strobe), .wq_addr(wq_addr),
        .status_bus(status_bus), .status_oe(status_oe), .wq_af_n(wq_af_n)
    );

    function automatic logic [7:0] quad_view(logic [31:0] f, logic [1:0] qd);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[b] = f[4*b + qd];
        return r;
    endfunction

    // Bench model of the latencies stated in the requirements
    logic [31:0] m_s1, m_s2;
    logic [1:0]  m_quad;
    logic        m_match, m_oe, m_paf;
    logic [4:0]  m_wq;
    logic [7:0]  m_bus;

    always @(posedge wclk) begin
        if (!wrst_n) begin
            m_s1 <= '1; m_s2 <= '1; m_quad <= 0; m_match <= 0;
            m_wq <= 0; m_bus <= 8'hFF; m_oe <= 0; m_paf <= 1;
        end else begin
            m_s1 <= af_rd_n;
            m_s2 <= m_s1;
            if (sel_strobe) begin
                m_quad  <= sel_addr[1:0];
                m_match <= (sel_addr[7:5] == 3'(MYID));
            end
            if (wq_strobe) m_wq <= wq_addr;
            m_bus <= quad_view(m_s2, m_quad);
            m_oe  <= m_match;
            m_paf <= m_s2[m_wq];
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wrst_n = 0; af_rd_n = '1; sel_strobe = 0; sel_addr = 0;
        wq_strobe = 0; wq_addr = 0;
        repeat (4) @(negedge wclk);
        chk("R1 oe in reset", 32'(status_oe), 0);
        chk("R1 bus in reset", 32'(status_bus), 32'hFF);
        chk("R1 paf in reset", 32'(wq_af_n), 1);
        wrst_n = 1;
        repeat (2) @(negedge wclk);
        chk("R1 oe after reset", 32'(status_oe), 0);
        chk("R1 paf after reset", 32'(wq_af_n), 1);

        // R3/R4: select own device, quadrant 3 (queue 31)
        sel_strobe = 1; sel_addr = {3'(MYID), 5'b11111};
        @(negedge wclk);
        sel_strobe = 0;
        chk("R3 old selection after sample edge", 32'(status_oe), 0);
        @(negedge wclk);
        chk("R4 oe on own id", 32'(status_oe), 1);
        chk("R3 bus quad3 idle", 32'(status_bus), 32'hFF);

        // R5/R2: queue 31 goes almost full
        af_rd_n[31] = 1'b0;
        @(negedge wclk);
        chk("R5 edge1 no change", 32'(status_bus[7]), 1);
        @(negedge wclk);
        chk("R5 edge2 no change", 32'(status_bus[7]), 1);
        @(negedge wclk);
        chk("R5 edge3 flag low", 32'(status_bus[7]), 0);
        chk("R2 only bit7", 32'(status_bus), 32'h7F);

        // R6: active write queue 31
        wq_strobe = 1; wq_addr = 5'd31;
        @(negedge wclk);
        wq_strobe = 0;
        chk("R6 old write queue", 32'(wq_af_n), 1);
        @(negedge wclk);
        chk("R6 write queue 31 flag", 32'(wq_af_n), 0);

        // R2: quadrant 0 must not show queue 31
        sel_strobe = 1; sel_addr = {3'(MYID), 5'b00000};
        @(negedge wclk);
        sel_strobe = 0;
        @(negedge wclk);
        chk("R2 quad0 view", 32'(status_bus), 32'hFF);

        // R4: foreign device releases
        sel_strobe = 1; sel_addr = {3'(MYID ^ 1), 5'b11111};
        @(negedge wclk);
        sel_strobe = 0;
        chk("R4 oe before release", 32'(status_oe), 1);
        @(negedge wclk);
        chk("R4 oe foreign id", 32'(status_oe), 0);

        // R7: no strobe, selection held
        repeat (3) @(negedge wclk);
        chk("R7 oe held", 32'(status_oe), 0);

        // Random phase against the model
        void'($urandom(32'd1234));
        for (int n = 0; n < 2000; n++) begin
            if (n > 0) begin
                chk("R2 R3 R5 bus", 32'(status_bus), 32'(m_bus));
                chk("R4 oe", 32'(status_oe), 32'(m_oe));
                chk("R6 paf", 32'(wq_af_n), 32'(m_paf));
            end
            if ($urandom_range(3) == 0) af_rd_n = af_rd_n ^ (32'd1 << $urandom_range(31));
            sel_strobe = ($urandom_range(9) < 3);
            sel_addr   = {($urandom_range(1) == 0) ? 3'(MYID) : 3'($urandom), 5'($urandom)};
            wq_strobe  = ($urandom_range(9) < 2);
            wq_addr    = 5'($urandom);
            @(negedge wclk);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule